// File: doc/BRIEF.md
# Indexed Byte-Port Memory Bridge With Region Locks

This block lets a host reach a byte-wide memory with a 16-bit address space through a window of only four byte-wide I/O ports. The host first builds a 16-bit address in an internal latch by writing its two halves through two separate ports. It then reads or writes the addressed byte through a data port. The block drives a plain synchronous memory: address, write data, write enable, read enable and read data.

Two 16-byte address regions can be protected. Each has its own lock bit, flipped by a toggle command. While a region is locked, stores into it are silently dropped and loads from it return all-ones. Addresses at or above the configured memory size behave the same way. After every store through the data port, the address latch returns to zero, whether or not the byte was stored. Read data appears on the host side one cycle after the read strobe.

Top module: `nvram_bridge`

## Requirements
- R1: While reset is asserted and after it is released, the address latch is 0x0000 and both lock bits are clear. The first data-port read after reset returns the byte at address 0x0000, and addresses 0x20 to 0x3F can be accessed. During reset, mem_we is low and io_rdata is 0xFF.
- R2: A write to port 0 replaces bits 7:0 of the address latch with io_wdata and leaves bits 15:8 unchanged. A write to port 1 replaces bits 15:8 and leaves bits 7:0 unchanged.
- R3: A write to port 3 (the data port) stores io_wdata at the latched address, provided the access is permitted. In the next cycle the latch is 0x0000, whether or not the byte was stored.
- R4: A read of port 3 returns the byte at the latched address on io_rdata in the cycle after the strobe. A read leaves the latch unchanged.
- R5: A lock_toggle pulse flips lock bit lock_sel and leaves the other bit unchanged. Bit 0 guards addresses 0x20 to 0x2F and bit 1 guards 0x30 to 0x3F. The new value governs accesses from the following cycle onward.
- R6: A data-port write to a region whose lock bit is set produces no mem_we. A data-port read from such a region returns 0xFF. The stored byte is unchanged and can be read again once the region is unlocked.
- R7: For any latched address at or above MEM_SIZE (default 2048), a data-port read returns 0xFF and a data-port write produces no mem_we.
- R8: Reads of ports 0, 1 and 2 return 0xFF. Writes to port 2 change neither the latch nor the memory.
- R9: mem_we and mem_re are never high together. Each is raised only for a permitted data-port access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_sel | input | 1 | One-cycle access strobe for the I/O window |
| io_wr | input | 1 | 1 = write access, 0 = read access |
| io_port | input | 2 | Port index: 0 address low, 1 address high, 2 spare, 3 data |
| io_wdata | input | 8 | Write byte from the host |
| io_rdata | output | 8 | Read byte to the host, valid the cycle after a read strobe |
| lock_toggle | input | 1 | One-cycle pulse that flips a lock bit |
| lock_sel | input | 1 | Index of the lock bit to flip |
| mem_addr | output | 16 | Memory address (the latch contents) |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | 8 | Memory read byte, registered by the memory on the mem_re edge |

## Verification
The assertions assume the following about the inputs:
- io_sel carries one access per strobe, with io_wr and io_port steady while it is high.
- lock_sel always names an existing lock bit.
- The memory returns data in the cycle after mem_re.

The bench drives all inputs on the falling clock edge and issues only single-cycle strobes. It models the memory with exactly one cycle of read latency. It never toggles a lock with an out-of-range index, so the stimulus stays inside those assumptions.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        PORT_ADDR_LO = 2'd0,
        PORT_ADDR_HI = 2'd1,
        PORT_SPARE   = 2'd2,
        PORT_DATA    = 2'd3
    } io_port_e;

    localparam logic [BYTE_W-1:0] IDLE_BYTE = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } latch_st_t;

    typedef struct packed {
        logic pass;
    } rsp_st_t;
endpackage

// File: rtl/nvb_addr_latch.sv
module nvb_addr_latch
    import nvb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              clr,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [ADDR_W-1:0] addr_q
);
    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.addr = '0;
        end else if (ld_lo) begin
            st_d.addr[BYTE_W-1:0] = byte_in;
        end else if (ld_hi) begin
            st_d.addr[ADDR_W-1:BYTE_W] = byte_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_q = st_q.addr;

    // R3
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> addr_q == '0);

    // R2
    lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_lo && !clr) |=> addr_q[ADDR_W-1:BYTE_W] == $past(addr_q[ADDR_W-1:BYTE_W]));

    // R2
    hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hi && !clr && !ld_lo) |=> addr_q[BYTE_W-1:0] == $past(addr_q[BYTE_W-1:0]));

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_lo || ld_hi || clr) |=> $stable(addr_q));
endmodule

// File: rtl/nvb_lock_regs.sv
module nvb_lock_regs #(
    parameter int NUM_LOCKS = 2,
    localparam int LIDX_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 toggle,
    input  logic [LIDX_W-1:0]    sel,
    output logic [NUM_LOCKS-1:0] lock_q
);
    logic [NUM_LOCKS-1:0] lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        for (int i = 0; i < NUM_LOCKS; i++) begin
            if (toggle && (32'(sel) == i)) lk_d[i] = ~lk_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign lock_q = lk_q;

    // R5
    lock_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> $countones(lock_q ^ $past(lock_q)) == 1);

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !toggle |=> $stable(lock_q));

    // R1
    lock_reset_chk: assert property (@(posedge clk)
        !rst_n |=> lock_q == '0);
endmodule

// File: rtl/nvb_access_chk.sv
module nvb_access_chk
    import nvb_pkg::*;
#(
    parameter int MEM_SIZE  = 2048,
    parameter int NUM_LOCKS = 2,
    parameter int LOCK_BASE = 32,
    parameter int LOCK_SPAN = 16
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_LOCKS-1:0] lock_q,
    output logic                 in_range,
    output logic                 locked,
    output logic                 allow
);
    localparam logic [31:0] SIZE_W = 32'(MEM_SIZE);

    logic [31:0]          addr_w;
    logic [NUM_LOCKS-1:0] hit;

    assign addr_w = {{(32-ADDR_W){1'b0}}, addr};

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_region
        localparam logic [31:0] LO = 32'(LOCK_BASE + g * LOCK_SPAN);
        localparam logic [31:0] HI = 32'(LOCK_BASE + (g + 1) * LOCK_SPAN);
        assign hit[g] = (addr_w >= LO) && (addr_w < HI);
    end

    assign in_range = addr_w < SIZE_W;
    assign locked   = |(hit & lock_q);
    assign allow    = in_range && !locked;
endmodule

// File: rtl/nvram_bridge.sv
module nvram_bridge
    import nvb_pkg::*;
#(
    parameter int MEM_SIZE  = 2048,
    parameter int NUM_LOCKS = 2,
    parameter int LOCK_BASE = 32,
    parameter int LOCK_SPAN = 16,
    localparam int LIDX_W   = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_sel,
    input  logic              io_wr,
    input  logic [1:0]        io_port,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic [BYTE_W-1:0] io_rdata,
    input  logic              lock_toggle,
    input  logic [LIDX_W-1:0] lock_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [BYTE_W-1:0] mem_rdata
);
    io_port_e             port;
    logic                 wr_lo, wr_hi, wr_data, rd_data;
    logic [ADDR_W-1:0]    addr_q;
    logic [NUM_LOCKS-1:0] lock_q;
    logic                 in_range, locked, allow;
    rsp_st_t              rsp_d, rsp_q;

    assign port    = io_port_e'(io_port);
    assign wr_lo   = io_sel &&  io_wr && (port == PORT_ADDR_LO);
    assign wr_hi   = io_sel &&  io_wr && (port == PORT_ADDR_HI);
    assign wr_data = io_sel &&  io_wr && (port == PORT_DATA);
    assign rd_data = io_sel && !io_wr && (port == PORT_DATA);

    nvb_addr_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo   (wr_lo),
        .ld_hi   (wr_hi),
        .clr     (wr_data),
        .byte_in (io_wdata),
        .addr_q  (addr_q)
    );

    nvb_lock_regs #(.NUM_LOCKS(NUM_LOCKS)) u_locks (
        .clk    (clk),
        .rst_n  (rst_n),
        .toggle (lock_toggle),
        .sel    (lock_sel),
        .lock_q (lock_q)
    );

    nvb_access_chk #(
        .MEM_SIZE  (MEM_SIZE),
        .NUM_LOCKS (NUM_LOCKS),
        .LOCK_BASE (LOCK_BASE),
        .LOCK_SPAN (LOCK_SPAN)
    ) u_chk (
        .addr     (addr_q),
        .lock_q   (lock_q),
        .in_range (in_range),
        .locked   (locked),
        .allow    (allow)
    );

    always_comb begin
        rsp_d      = rsp_q;
        rsp_d.pass = rd_data && allow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = io_wdata;
    assign mem_we    = wr_data && allow;
    assign mem_re    = rd_data && allow;
    assign io_rdata  = rsp_q.pass ? mem_rdata : IDLE_BYTE;

    // R9
    mem_ops_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re}));

    // R9
    we_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (io_sel && io_port == 2'd3));

    // R7
    range_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> ({{(32-ADDR_W){1'b0}}, mem_addr} < 32'(MEM_SIZE)));

    // R8
    nondata_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && !io_wr && io_port != 2'd3) |=> io_rdata == IDLE_BYTE);

    // R4
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> io_rdata == mem_rdata);

    // R7
    range_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && !io_wr && !in_range) |=> io_rdata == IDLE_BYTE);

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock_chk
        localparam logic [31:0] RLO = 32'(LOCK_BASE + g * LOCK_SPAN);
        localparam logic [31:0] RHI = 32'(LOCK_BASE + (g + 1) * LOCK_SPAN);
        // R6
        locked_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_we || mem_re) |-> !(lock_q[g] &&
                ({{(32-ADDR_W){1'b0}}, mem_addr} >= RLO) &&
                ({{(32-ADDR_W){1'b0}}, mem_addr} <  RHI)));
    end

    // R6
    locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && !io_wr && locked) |=> io_rdata == IDLE_BYTE);
endmodule

// File: tb/tb_nvram_bridge.sv
module tb_nvram_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int MEM = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_sel = 1'b0, io_wr = 1'b0;
    logic [1:0]  io_port = 2'd0;
    logic [7:0]  io_wdata = 8'd0;
    logic [7:0]  io_rdata;
    logic        lock_toggle = 1'b0;
    logic [0:0]  lock_sel = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_we, mem_re;

    nvram_bridge dut (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr),
        .io_port(io_port), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .lock_toggle(lock_toggle), .lock_sel(lock_sel),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] ram [MEM];
    logic [7:0] ram_q = 8'd0;
    assign mem_rdata = ram_q;

    int we_cnt = 0, oob_we = 0;
    always @(posedge clk) begin
        if (mem_we) begin
            we_cnt <= we_cnt + 1;
            if (32'(mem_addr) < MEM) ram[mem_addr[10:0]] <= mem_wdata;
            else oob_we <= oob_we + 1;
        end
        if (mem_re && 32'(mem_addr) < MEM) ram_q <= ram[mem_addr[10:0]];
    end

    // reference model
    logic [7:0]  mdl_mem [MEM];
    logic [1:0]  lock_m = 2'b00;
    logic [15:0] lat_m = 16'd0;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] q_val [$];
    string      q_tag [$];

    function automatic logic [7:0] exp_read();
        if (32'(lat_m) >= MEM) return 8'hFF;
        if (lat_m >= 16'h20 && lat_m <= 16'h2F && lock_m[0]) return 8'hFF;
        if (lat_m >= 16'h30 && lat_m <= 16'h3F && lock_m[1]) return 8'hFF;
        return mdl_mem[lat_m[10:0]];
    endfunction

    function automatic bool_allowed();
        return exp_read() != 8'hFF || (32'(lat_m) < MEM && !(
            (lat_m >= 16'h20 && lat_m <= 16'h2F && lock_m[0]) ||
            (lat_m >= 16'h30 && lat_m <= 16'h3F && lock_m[1])));
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per completed read strobe
    logic rd_pend = 1'b0;
    always @(posedge clk) rd_pend <= rst_n && io_sel && !io_wr;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (q_val.size() == 0) begin
                check_int("SCOREBOARD underflow", 1, 0);
            end else begin
                check(q_tag.pop_front(), io_rdata, q_val.pop_front());
            end
        end
    end

    task automatic io_write(input logic [1:0] p, input logic [7:0] d);
        io_sel = 1'b1; io_wr = 1'b1; io_port = p; io_wdata = d;
        case (p)
            2'd0: lat_m[7:0]  = d;
            2'd1: lat_m[15:8] = d;
            2'd3: begin
                if (bool_allowed()) mdl_mem[lat_m[10:0]] = d;
                lat_m = 16'd0;
            end
            default: ;
        endcase
        @(negedge clk);
        io_sel = 1'b0; io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [1:0] p, input string tag);
        io_sel = 1'b1; io_wr = 1'b0; io_port = p;
        q_val.push_back(p == 2'd3 ? exp_read() : 8'hFF);
        q_tag.push_back(tag);
        @(negedge clk);
        io_sel = 1'b0;
    endtask

    task automatic set_addr(input logic [15:0] a);
        io_write(2'd0, a[7:0]);
        io_write(2'd1, a[15:8]);
    endtask

    task automatic toggle(input int i);
        lock_toggle = 1'b1; lock_sel = 1'(i);
        lock_m[i] = ~lock_m[i];
        @(negedge clk);
        lock_toggle = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int we0;
        for (int i = 0; i < MEM; i++) begin
            ram[i] = 8'(i * 7 + 3);
            mdl_mem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        check("R1 reset mem_we", {7'd0, mem_we}, 8'd0);
        check("R1 reset io_rdata", io_rdata, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);

        io_read(2'd3, "R1 first read at 0x0000");
        set_addr(16'h0025);
        io_read(2'd3, "R1 lock region open after reset");

        set_addr(16'h0123);
        io_write(2'd3, 8'h5A);
        io_read(2'd3, "R3 latch cleared after data write");
        set_addr(16'h0123);
        io_read(2'd3, "R4 read stored byte");
        io_read(2'd3, "R4 repeated read keeps latch");

        set_addr(16'h0010);
        io_write(2'd1, 8'h07);
        io_read(2'd3, "R2 high byte replaced only");
        io_write(2'd0, 8'hFF);
        io_read(2'd3, "R2 low byte replaced only at 0x07FF");

        io_read(2'd0, "R8 port0 read");
        io_read(2'd1, "R8 port1 read");
        io_read(2'd2, "R8 port2 read");
        io_write(2'd2, 8'h99);
        io_read(2'd3, "R8 port2 write no effect");

        set_addr(16'h0800);
        io_read(2'd3, "R7 read at size limit");
        we0 = we_cnt;
        io_write(2'd3, 8'hAA);
        @(negedge clk);
        check_int("R7 no mem_we out of range", we_cnt, we0);
        set_addr(16'hFFFF);
        io_read(2'd3, "R7 read at 0xFFFF");

        toggle(0);
        set_addr(16'h0020);
        we0 = we_cnt;
        io_write(2'd3, 8'h11);
        @(negedge clk);
        check_int("R6 no mem_we when locked", we_cnt, we0);
        io_read(2'd3, "R3 latch cleared after dropped write");
        set_addr(16'h002F);
        io_read(2'd3, "R6 locked read 0x2F");
        set_addr(16'h0030);
        io_write(2'd3, 8'h22);
        set_addr(16'h0030);
        io_read(2'd3, "R5 region1 unaffected by lock0");
        set_addr(16'h001F);
        io_read(2'd3, "R5 below region open");
        toggle(1);
        set_addr(16'h003F);
        io_read(2'd3, "R6 locked read 0x3F");
        set_addr(16'h0040);
        io_read(2'd3, "R5 above region open");
        toggle(0);
        set_addr(16'h0020);
        io_read(2'd3, "R6 dropped write left byte intact");
        toggle(1);
        set_addr(16'h0030);
        io_read(2'd3, "R5 region1 unlocked again");

        repeat (3) @(negedge clk);
        check_int("R7 out-of-range writes", oob_we, 0);
        check_int("R4 scoreboard drained", q_val.size(), 0);
        finish_run();
    end
endmodule